// File: doc/BRIEF.md
# Address-Dependent CPU Clock Rate Generator

This block turns a master crystal clock into the two quadrature clock phases of a processor bus. Each processor cycle lasts either sixteen crystal clocks (slow) or eight crystal clocks (fast). A two-bit rate setting chooses among three behaviours: always slow, always fast, or a per-cycle choice made from the address the processor is driving. In the per-cycle mode, cycles aimed at the lower half of the address space (dynamic RAM) or at a small low I/O window run slow. Cycles aimed anywhere else, such as ROM or the upper I/O ports, run fast.

The choice is made once, on the crystal edge that opens a cycle, from the address present on that edge. A cycle therefore never changes length once it has begun. Both phases are decoded from the position inside the current cycle. Each phase changes level on quarter boundaries, so the quadrature relationship holds at both rates. The processor only touches external memory in the second half of a cycle, so the address is stable well before the next opening edge. A rate indicator is high for the whole of every fast cycle.

Top module: `cpu_rate_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the rate setting is 2'b00, the cycle is slow (16 crystal clocks), and `cpu_q`, `cpu_e` and `fast_cycle` are low.
- R2: With rate setting 2'b00, every cycle lasts 16 crystal clocks whatever the address.
- R3: With rate setting 2'b10 or 2'b11 (upper bit set), every cycle lasts 8 crystal clocks whatever the address.
- R4: With rate setting 2'b01, a cycle whose address is 0x0000 to 0x7FFF lasts 16 crystal clocks.
- R5: With rate setting 2'b01, a cycle whose address is 0xFF00 to 0xFF1F lasts 16 crystal clocks.
- R6: With rate setting 2'b01, a cycle with any other address (0x8000 to 0xFEFF, 0xFF20 to 0xFFFF) lasts 8 crystal clocks.
- R7: Positions in a cycle of length L are counted 0 to L-1 from the opening edge. `cpu_q` is high for positions L/4 to 3L/4-1. `cpu_e` is high for positions L/2 to L-1. Both phases are low in the first quarter.
- R8: The length of a cycle is decided only from the address present on the crystal edge that opens it. Address changes during the cycle have no effect on its length or on its phases.
- R9: A write (`rate_wr` high on a crystal edge, value on `rate_wdata`) updates the rate setting. It first governs the cycle opened on a later edge. A cycle already running, or one opened on the same edge as the write, keeps the length decided under the old setting.
- R10: `fast_cycle` is high through every position of an 8-clock cycle and low through every position of a 16-clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Master crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Address driven by the processor |
| rate_wr | input | 1 | Decoded write strobe for the rate setting |
| rate_wdata | input | 2 | New rate setting (bit 1 forces fast, 2'b01 selects per-address) |
| cpu_q | output | 1 | Leading quadrature clock phase |
| cpu_e | output | 1 | Trailing clock phase; high during the data half of the cycle |
| fast_cycle | output | 1 | High during 8-clock cycles |

## Verification
The hardest situation to reach from the ports is a cycle boundary that falls together with an address change or a rate write. A wrong choice of sampling edge only shows up when the address or the setting changes within one clock of the boundary. The stimulus does two things to reach it. First, it toggles the address every crystal clock between a slow region and a fast region for hundreds of clocks, so every offset against the boundary is visited. Second, it issues rate writes at several different positions inside a cycle. A behavioural countdown model in the bench predicts the phases and the indicator for every clock. An independent length measurement, taken between falling edges of the trailing phase, ties the indicator to the real cycle length.

// File: rtl/cpu_rate_pkg.sv
package cpu_rate_pkg;

  typedef enum logic [1:0] {
    RATE_ALL_SLOW = 2'b00,
    RATE_BY_ADDR  = 2'b01,
    RATE_ALL_FAST = 2'b10,
    RATE_FAST_ALT = 2'b11
  } rate_sel_e;

  // true when lo <= v <= hi
  function automatic logic in_window(input int unsigned v,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // true when lo <= v < hi
  function automatic logic in_span(input int unsigned v,
                                   input int unsigned lo,
                                   input int unsigned hi);
    return (v >= lo) && (v < hi);
  endfunction

  // leading phase: second and third quarter of a cycle of length len
  function automatic logic lead_phase(input int unsigned pos,
                                      input int unsigned len);
    return in_span(pos, len / 4, (3 * len) / 4);
  endfunction

  // trailing phase: second half of a cycle of length len
  function automatic logic trail_phase(input int unsigned pos,
                                       input int unsigned len);
    return in_span(pos, len / 2, len);
  endfunction

endpackage

// File: rtl/rate_ctrl_reg.sv
module rate_ctrl_reg
  import cpu_rate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [1:0] wr_data,
  output rate_sel_e rate_o
);

  rate_sel_e rate_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_r <= RATE_ALL_SLOW;
    end else if (wr_en) begin
      rate_r <= rate_sel_e'(wr_data);
    end
  end

  assign rate_o = rate_r;

endmodule

// File: rtl/rate_region_decode.sv
module rate_region_decode
  import cpu_rate_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned RAM_LAST    = 32'h7FFF,
  parameter bit          LOWIO_EN    = 1'b1,
  parameter int unsigned LOWIO_FIRST = 32'hFF00,
  parameter int unsigned LOWIO_LAST  = 32'hFF1F
) (
  input  logic [ADDR_W-1:0] addr,
  input  rate_sel_e         rate,
  output logic              slow_region,
  output logic              want_fast
);

  logic ram_hit;
  logic lowio_hit;

  assign ram_hit = in_window(32'(addr), 0, RAM_LAST);

  generate
    if (LOWIO_EN) begin : g_lowio
      assign lowio_hit = in_window(32'(addr), LOWIO_FIRST, LOWIO_LAST);
    end else begin : g_no_lowio
      assign lowio_hit = 1'b0;
    end
  endgenerate

  assign slow_region = ram_hit || lowio_hit;

  always_comb begin
    unique case (rate)
      RATE_ALL_SLOW: want_fast = 1'b0;
      RATE_BY_ADDR:  want_fast = !slow_region;
      default:       want_fast = 1'b1;
    endcase
  end

endmodule

// File: rtl/cycle_phase_gen.sv
module cycle_phase_gen
  import cpu_rate_pkg::*;
#(
  parameter int unsigned SLOW_DIV = 16,
  parameter int unsigned FAST_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic next_fast,
  output logic last_tick,
  output logic cyc_start,
  output logic phase_q,
  output logic phase_e,
  output logic fast_o
);

  localparam int unsigned LEN_W = $clog2(SLOW_DIV) + 1;
  localparam logic [LEN_W-1:0] SLOW_LEN = LEN_W'(SLOW_DIV);
  localparam logic [LEN_W-1:0] FAST_LEN = LEN_W'(FAST_DIV);
  localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);

  logic [LEN_W-1:0] pos_q;
  logic [LEN_W-1:0] len_cur;
  logic             fast_q;

  assign len_cur   = fast_q ? FAST_LEN : SLOW_LEN;
  assign last_tick = (pos_q == (len_cur - ONE));
  assign cyc_start = (pos_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      fast_q <= 1'b0;
    end else if (last_tick) begin
      pos_q  <= '0;
      fast_q <= next_fast;
    end else begin
      pos_q  <= pos_q + ONE;
    end
  end

  assign phase_q = lead_phase(32'(pos_q), 32'(len_cur));
  assign phase_e = trail_phase(32'(pos_q), 32'(len_cur));
  assign fast_o  = fast_q;

endmodule

// File: rtl/cpu_rate_gen.sv
module cpu_rate_gen
  import cpu_rate_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SLOW_DIV    = 16,
  parameter int unsigned FAST_DIV    = 8,
  parameter int unsigned RAM_LAST    = 32'h7FFF,
  parameter bit          LOWIO_EN    = 1'b1,
  parameter int unsigned LOWIO_FIRST = 32'hFF00,
  parameter int unsigned LOWIO_LAST  = 32'hFF1F
) (
  input  logic              clk_xtal,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              rate_wr,
  input  logic [1:0]        rate_wdata,
  output logic              cpu_q,
  output logic              cpu_e,
  output logic              fast_cycle
);

  rate_sel_e rate_q;
  logic      slow_region;
  logic      want_fast;
  logic      last_tick;
  logic      cyc_start;

  rate_ctrl_reg u_reg (
    .clk     (clk_xtal),
    .rst_n   (rst_n),
    .wr_en   (rate_wr),
    .wr_data (rate_wdata),
    .rate_o  (rate_q)
  );

  rate_region_decode #(
    .ADDR_W      (ADDR_W),
    .RAM_LAST    (RAM_LAST),
    .LOWIO_EN    (LOWIO_EN),
    .LOWIO_FIRST (LOWIO_FIRST),
    .LOWIO_LAST  (LOWIO_LAST)
  ) u_dec (
    .addr        (cpu_addr),
    .rate        (rate_q),
    .slow_region (slow_region),
    .want_fast   (want_fast)
  );

  cycle_phase_gen #(
    .SLOW_DIV (SLOW_DIV),
    .FAST_DIV (FAST_DIV)
  ) u_gen (
    .clk       (clk_xtal),
    .rst_n     (rst_n),
    .next_fast (want_fast),
    .last_tick (last_tick),
    .cyc_start (cyc_start),
    .phase_q   (cpu_q),
    .phase_e   (cpu_e),
    .fast_o    (fast_cycle)
  );

endmodule

// File: rtl/cpu_rate_gen_chk.sv
module cpu_rate_gen_chk
  import cpu_rate_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input rate_sel_e   rate,
  input logic        last_tick,
  input logic        cyc_start,
  input logic        q,
  input logic        e,
  input logic        fast
);

  AST_E_AFTER_Q: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(e) |-> q);  // R7

  AST_Q_BEFORE_E: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> !e);  // R7

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> (!q && !e));  // R7

  AST_LEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |-> $stable(fast));  // R8

  AST_ALL_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (last_tick && rate == RATE_ALL_SLOW) |=> !fast);  // R2

  AST_ALL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (last_tick && rate[1]) |=> fast);  // R3

  AST_RAM_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (last_tick && rate == RATE_BY_ADDR && !addr[15]) |=> !fast);  // R4

  AST_LOWIO_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (last_tick && rate == RATE_BY_ADDR && addr[15:5] == 11'h7F8) |=> !fast);  // R5

  AST_ROM_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (last_tick && rate == RATE_BY_ADDR && addr[15] && addr[15:8] != 8'hFF) |=> fast);  // R6

endmodule

bind cpu_rate_gen cpu_rate_gen_chk u_chk (
  .clk       (clk_xtal),
  .rst_n     (rst_n),
  .addr      (cpu_addr),
  .rate      (rate_q),
  .last_tick (last_tick),
  .cyc_start (cyc_start),
  .q         (cpu_q),
  .e         (cpu_e),
  .fast      (fast_cycle)
);

// File: tb/cpu_rate_gen_bench.sv
module cpu_rate_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        rate_wr = 1'b0;
  logic [1:0]  rate_wdata = 2'b00;
  logic        cpu_q;
  logic        cpu_e;
  logic        fast_cycle;

  always #10 clk = ~clk;  // 50 MHz

  cpu_rate_gen u_cpu_rate_gen (
    .clk_xtal   (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .rate_wr    (rate_wr),
    .rate_wdata (rate_wdata),
    .cpu_q      (cpu_q),
    .cpu_e      (cpu_e),
    .fast_cycle (fast_cycle)
  );

  int    compared = 0;
  int    mismatched = 0;
  string cur_req = "R1";
  int    ticks = 0;
  bit    done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s act=%0d exp=%0d at tick %0d", req, what, act, exp, ticks);
    end
  endtask

  // behavioural model: remaining clocks in the current cycle
  int m_len = 16;
  int m_left = 16;
  int m_rate = 0;

  function automatic int pick_len(input int a, input int r);
    if (r >= 2) return 8;
    if (r == 0) return 16;
    if (a < 32768) return 16;
    if (a >= 65280 && a <= 65311) return 16;
    return 8;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_len = 16; m_left = 16; m_rate = 0;
    end else begin
      if (m_left == 1) begin
        m_len  = pick_len(int'(cpu_addr), m_rate);
        m_left = m_len;
      end else begin
        m_left = m_left - 1;
      end
      if (rate_wr) m_rate = int'(rate_wdata);
    end
  end

  // per-clock comparison and independent length measurement
  logic prev_e = 1'b0;
  logic prev_fast = 1'b0;
  int   last_fall = -1;

  always @(negedge clk) begin
    int el;
    ticks++;
    if (!done) begin
      el = m_len - m_left;
      chk("R7", "cpu_q", int'(cpu_q), int'(el * 4 >= m_len && el * 4 < 3 * m_len));
      chk("R7", "cpu_e", int'(cpu_e), int'(el * 2 >= m_len));
      chk(cur_req, "fast_cycle", int'(fast_cycle), int'(m_len == 8));
      if (rst_n && prev_e && !cpu_e) begin
        if (last_fall >= 0)
          chk("R10", "cycle length vs indicator", ticks - last_fall, prev_fast ? 8 : 16);
        last_fall = ticks;
      end
      if (!rst_n) last_fall = -1;
      prev_e = cpu_e;
      prev_fast = fast_cycle;
    end
    if (ticks > 150000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog act=%0d ticks exp=finish before 150000", ticks);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_rate(input logic [1:0] v);
    @(negedge clk);
    rate_wr = 1'b1; rate_wdata = v;
    @(negedge clk);
    rate_wr = 1'b0;
  endtask

  task automatic hold_addr(input string req, input logic [15:0] a, input int n);
    @(negedge clk);
    cur_req = req;
    cpu_addr = a;
    step(n);
  endtask

  initial begin
    cur_req = "R1";
    step(4);
    chk("R1", "reset cpu_q", int'(cpu_q), 0);
    chk("R1", "reset cpu_e", int'(cpu_e), 0);
    chk("R1", "reset fast_cycle", int'(fast_cycle), 0);
    cpu_addr = 16'h8000;
    rst_n = 1'b1;
    step(2);
    chk("R1", "first cycle slow", int'(fast_cycle), 0);

    hold_addr("R2", 16'h8000, 48);
    hold_addr("R2", 16'hFFFF, 40);

    // write mid-cycle: current cycle keeps its length
    step(5);
    cur_req = "R9";
    write_rate(2'b10);
    chk("R9", "no change mid-cycle", int'(fast_cycle), 0);
    step(20);
    hold_addr("R3", 16'h0000, 40);
    write_rate(2'b11);
    hold_addr("R3", 16'hFF00, 40);

    // back to per-address, written at another offset
    step(3);
    cur_req = "R9";
    write_rate(2'b01);
    step(20);
    hold_addr("R4", 16'h0000, 48);
    hold_addr("R4", 16'h7FFF, 48);
    hold_addr("R6", 16'h8000, 32);
    hold_addr("R6", 16'hFEFF, 32);
    hold_addr("R6", 16'hFFEF, 32);
    hold_addr("R5", 16'hFF00, 48);
    hold_addr("R5", 16'hFF1F, 48);
    hold_addr("R6", 16'hFF20, 32);
    hold_addr("R6", 16'hFF5F, 32);
    hold_addr("R6", 16'hFFFF, 32);

    // address toggling every clock: every offset against the boundary
    cur_req = "R8";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      cpu_addr = ((i % 3) == 0) ? 16'h7FFF : (((i % 5) == 0) ? 16'hFF1F : 16'hFF20);
    end

    // writes at several offsets while addresses alternate
    for (int k = 0; k < 6; k++) begin
      cur_req = "R9";
      step(k + 1);
      write_rate(k[0] ? 2'b01 : 2'b10);
      cpu_addr = k[1] ? 16'h1234 : 16'hC000;
      step(11);
    end
    write_rate(2'b00);
    hold_addr("R2", 16'hA000, 48);

    step(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule